// File: doc/BRIEF.md
# Illegal Opcode Trap Injector

This block sits in the read path between the external data bus of an 8-bit processor and the processor's data input. It holds a one-bit-per-byte map that marks opcode values the processor does not implement. When the processor reads a byte and signals that the read is an opcode fetch, the block looks the byte up in the map. If the byte is marked, the block replaces it with the break opcode 0x00. The processor then takes its break vector at 0xFFFE/0xFFFF. A handler there inspects the stacked return address to tell a genuine break from a trapped opcode.

Operand bytes and load/store data pass through unchanged, whatever their value. The substitution path is purely combinational, so the forced value is present within the same read cycle. Each substitution produces a one-cycle event and captures the original byte in a holding register with a valid flag. Software clears that flag by pulsing an acknowledge input. The map is filled through a write port and resets to all zeros, which means pure pass-through.

Top module: `opcode_trap_injector`

## Requirements
- R1: After reset, trap_flag is 0, trap_op is 0x00 and every map entry is 0, so every byte read, including opcode fetches, appears unchanged on cpu_dout.
- R2: When fetch and rd_en are both 1 and the map entry indexed by bus_din is 1, cpu_dout is 0x00 and trap_pulse is 1 in the same cycle, with no clock edge in between.
- R3: When fetch or rd_en is 0, cpu_dout equals bus_din and trap_pulse is 0, even if the map entry for bus_din is 1.
- R4: During an opcode fetch (fetch and rd_en both 1) of a byte whose map entry is 0, cpu_dout equals bus_din and trap_pulse is 0.
- R5: The map entry for 0x00 always stays 0. A write with map_addr 0x00 and map_wdata 1 has no effect, so a fetched 0x00 never raises trap_pulse.
- R6: A write (map_we 1) stores map_wdata at entry map_addr on the clock edge. A lookup in the same cycle as the write still uses the old entry, and the new entry is used from the next cycle on.
- R7: On the clock edge that ends a cycle with trap_pulse 1 while trap_flag is 0, trap_flag becomes 1 and trap_op takes the value bus_din had in that cycle.
- R8: While trap_flag is 1 and trap_ack is 0, trap_op and trap_flag hold, even if further traps occur.
- R9: A cycle with trap_ack 1 and trap_pulse 0 clears trap_flag on its edge. If trap_ack and trap_pulse are both 1, trap_flag stays 1 and trap_op takes the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_din | input | 8 | Byte from the memory-side data bus |
| fetch | input | 1 | Processor signals an opcode fetch cycle |
| rd_en | input | 1 | Processor read strobe |
| cpu_dout | output | 8 | Byte presented to the processor |
| trap_pulse | output | 1 | High in a cycle whose byte is being replaced |
| map_we | input | 1 | Map write enable |
| map_addr | input | 8 | Map entry to write |
| map_wdata | input | 1 | Value written to the entry (1 = unimplemented) |
| trap_ack | input | 1 | Clears the captured trap |
| trap_flag | output | 1 | A captured trap is pending |
| trap_op | output | 8 | Original byte of the captured trap |

## Verification
The lookup is tried with bytes that are marked and unmarked, under all four combinations of the fetch and read strobes. This separates true substitution from pass-through in operand and data cycles. Directed cases cover a write to entry 0x00, a write and a lookup in the same cycle, and an acknowledge in the same cycle as a new trap. These show the break value passing through, the one-cycle delay of map updates, and the priority of a new trap over a clear. Random traffic, biased toward a small set of byte values so that map hits are frequent, then mixes repeated traps while one is pending with acknowledges. This shows that the captured byte stays frozen until it is cleared.

// File: rtl/opcode_trap_injector.sv
module opcode_trap_injector #(
  parameter int unsigned DW = 8,
  parameter logic [7:0]  BRK_OP = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_din,
  input  logic          fetch,
  input  logic          rd_en,
  output logic [DW-1:0] cpu_dout,
  output logic          trap_pulse,
  input  logic          map_we,
  input  logic [DW-1:0] map_addr,
  input  logic          map_wdata,
  input  logic          trap_ack,
  output logic          trap_flag,
  output logic [DW-1:0] trap_op
);
  localparam int unsigned DEPTH = 1 << DW;
  localparam logic [DW-1:0] FORCED = BRK_OP[DW-1:0];

  logic [DEPTH-1:0] ill_map;
  logic             hit;

  always_ff @(posedge clk) begin
    if (!rst_n)      ill_map <= '0;
    else if (map_we) ill_map[map_addr] <= map_wdata && (map_addr != FORCED);
  end

  assign hit        = fetch & rd_en & ill_map[bus_din];
  assign trap_pulse = hit;
  assign cpu_dout   = hit ? FORCED : bus_din;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_flag <= 1'b0;
      trap_op   <= '0;
    end else if (hit && (!trap_flag || trap_ack)) begin
      trap_flag <= 1'b1;
      trap_op   <= bus_din;
    end else if (trap_ack) begin
      trap_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/opcode_trap_injector_chk.sv
module opcode_trap_injector_chk #(
  parameter int unsigned DW = 8,
  parameter logic [7:0]  BRK_OP = 8'h00
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] bus_din,
  input logic          fetch,
  input logic          rd_en,
  input logic [DW-1:0] cpu_dout,
  input logic          trap_pulse,
  input logic          map_we,
  input logic [DW-1:0] map_addr,
  input logic          map_wdata,
  input logic          trap_ack,
  input logic          trap_flag,
  input logic [DW-1:0] trap_op
);
  a_r2_forced_value: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> cpu_dout == BRK_OP[DW-1:0]);

  a_r3_no_trap_off_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch && rd_en) |-> (cpu_dout == bus_din) && !trap_pulse);

  a_r5_break_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && rd_en && bus_din == BRK_OP[DW-1:0]) |-> !trap_pulse);

  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pulse && !trap_flag) |=> trap_flag && (trap_op == $past(bus_din)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_flag && !trap_ack) |=> trap_flag && $stable(trap_op));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ack && !trap_pulse) |=> !trap_flag);
endmodule

bind opcode_trap_injector opcode_trap_injector_chk #(.DW(DW), .BRK_OP(BRK_OP)) u_chk (.*);

// File: tb/test_opcode_trap_injector.sv
module test_opcode_trap_injector;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_din = '0, map_addr = '0;
  logic fetch = 0, rd_en = 0, map_we = 0, map_wdata = 0, trap_ack = 0;
  logic [7:0] cpu_dout, trap_op;
  logic trap_pulse, trap_flag;

  int checks = 0, failures = 0;
  bit [255:0] m_map;
  bit m_flag;
  logic [7:0] m_op;
  bit done = 0;

  always #2 clk = ~clk;

  opcode_trap_injector i_opcode_trap_injector (.*);

  function automatic bit exp_hit(bit f, bit r, logic [7:0] d);
    return f && r && m_map[d];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(bit f, bit r, logic [7:0] d, bit we, logic [7:0] a, bit wd, bit ack);
    bit h;
    string rq;
    @(negedge clk);
    fetch = f; rd_en = r; bus_din = d; map_we = we; map_addr = a; map_wdata = wd; trap_ack = ack;
    #1;
    h = exp_hit(f, r, d);
    if (h) rq = "R2";
    else if (!(f && r)) rq = "R3";
    else if (d == 8'h00) rq = "R5";
    else if (we && a == d) rq = "R6";
    else rq = "R4";
    chk(rq, {cpu_dout, trap_pulse}, {(h ? 8'h00 : d), h});
    if (h && (!m_flag || ack)) begin m_flag = 1; m_op = d; rq = ack ? "R9" : "R7"; end
    else if (ack) begin m_flag = 0; rq = "R9"; end
    else rq = "R8";
    if (we) m_map[a] = wd && (a != 8'h00);
    @(posedge clk); #1;
    chk(rq, {trap_flag, trap_op}, {m_flag, m_op});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    m_map = '0; m_flag = 0; m_op = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1", {trap_flag, trap_op}, 9'h000);
    for (int v = 0; v < 256; v++) step(1, 1, v[7:0], 0, 0, 0, 0);
    // R6: write and lookup in the same cycle uses the old entry
    step(1, 1, 8'h3C, 1, 8'h3C, 1, 0);
    step(1, 1, 8'h3C, 0, 0, 0, 0);
    // R3: operand/data cycles with a marked value
    step(0, 1, 8'h3C, 0, 0, 0, 0);
    step(1, 0, 8'h3C, 0, 0, 0, 0);
    // R8: second trap while pending
    step(1, 1, 8'h3C, 1, 8'h5A, 1, 0);
    step(1, 1, 8'h5A, 0, 0, 0, 0);
    // R9: ack with new trap, then plain ack
    step(1, 1, 8'h5A, 0, 0, 0, 1);
    step(0, 0, 8'h00, 0, 0, 0, 1);
    // R5: entry 0x00 cannot be marked
    step(0, 0, 8'h00, 1, 8'h00, 1, 0);
    step(1, 1, 8'h00, 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] d, a;
      d = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 16);
      a = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 16);
      step($urandom % 2 == 0, $urandom % 4 != 0, d, $urandom % 4 == 0, a,
           $urandom % 3 != 0, $urandom % 8 == 0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule